// File: doc/BRIEF.md
# Accumulator Processor Core with Interrupt Check

A small 16-bit processor built around one accumulator. It keeps a program counter, an instruction register and the accumulator. It runs each instruction as a short sequence of states: it reads the instruction word, carries out the operation, and then looks for a pending interrupt before it reads the next instruction. It works with a synchronous single-port memory that returns read data one clock after the address is presented.

Each instruction word carries a 4-bit operation code in its top bits and a 12-bit memory address in its low bits. The core can load, add and store against memory, return from an interrupt, and halt. When it accepts an interrupt, it copies the program counter and the accumulator into shadow registers, blocks further interrupts, and continues at a fixed handler address. The return opcode brings both values back and unblocks interrupts.

Top module: `accu_core`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `memAddr` is 0, `memWe` is 0 and `irqAck` is 0. Reset clears the accumulator, so a store executed first writes 0.
- R2: An instruction is read from the address held in the program counter. Bits 15..12 of the word are the opcode and bits 11..0 are the operand address. The program counter then advances by one, modulo 2^12.
- R3: Opcode 0b0010 writes the accumulator to the operand address. `memWe` is high for exactly one cycle, with `memWdata` equal to the accumulator.
- R4: Opcode 0b0001 replaces the accumulator with the memory word at the operand address.
- R5: Opcode 0b0101 adds the memory word at the operand address to the accumulator, modulo 2^16.
- R6: After every executed instruction the core samples `irqReq`. If it is high and interrupts are unblocked, `irqAck` is high for that one cycle and the next instruction is read from address 0x100.
- R7: From an accepted interrupt until a return opcode executes, `irqAck` stays low even while `irqReq` is high.
- R8: Opcode 0b1111 restores the program counter and the accumulator saved at acceptance and unblocks interrupts. The interrupted program then continues with the next instruction, and its accumulator value is unchanged.
- R9: Opcode 0b0000 halts the core: no further instruction reads and no memory writes until reset, and `memAddr` holds steady.
- R10: Every other opcode value leaves the accumulator and memory unchanged, and execution continues with the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| memAddr | output | 12 | Memory word address |
| memWdata | output | 16 | Data written to memory |
| memRdata | input | 16 | Memory read data, valid one cycle after the address |
| memWe | output | 1 | Memory write enable |
| irqReq | input | 1 | Level-sensitive interrupt request |
| irqAck | output | 1 | One-cycle interrupt acceptance pulse |

## Verification
Any wrong internal state shows up at the memory port within one instruction. A bad program counter changes the next instruction read address, which is visible on `memAddr` a cycle after the execute step. A bad accumulator first appears as wrong `memWdata` at the next store, so every random program stores often, and its full write trace is compared against a bench interpreter. A lost context shows up as a wrong stored value, or as a skipped or repeated store, right after the return from the handler. A broken mask shows up as a second `irqAck` pulse while the request is held high inside the handler.

// File: rtl/accu_pkg.sv
package accu_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 12;
  localparam int OP_W   = DATA_W - ADDR_W;

  localparam logic [OP_W-1:0] OP_HALT  = 4'b0000;
  localparam logic [OP_W-1:0] OP_LOAD  = 4'b0001;
  localparam logic [OP_W-1:0] OP_STORE = 4'b0010;
  localparam logic [OP_W-1:0] OP_ADD   = 4'b0101;
  localparam logic [OP_W-1:0] OP_RETI  = 4'b1111;

  typedef enum logic [2:0] {
    S_FETCH, S_FWAIT, S_EXEC, S_OWAIT, S_ICHK, S_HALT
  } stateT;

  typedef struct packed {
    logic irLoad;
    logic pcInc;
    logic addrFromIr;
    logic accLoad;
    logic accAdd;
    logic ctxSave;
    logic ctxRestore;
    logic memWr;
  } ctrlT;
endpackage

// File: rtl/accu_ctrl.sv
module accu_ctrl
  import accu_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opcode,
  input  logic            irqReq,
  output ctrlT            st,
  output logic            irqAck
);
  stateT state, nextState;
  logic  masked;

  always_comb begin
    st        = '0;
    irqAck    = 1'b0;
    nextState = state;
    unique case (state)
      S_FETCH: nextState = S_FWAIT;
      S_FWAIT: begin
        st.irLoad = 1'b1;
        st.pcInc  = 1'b1;
        nextState = S_EXEC;
      end
      S_EXEC: begin
        st.addrFromIr = 1'b1;
        case (opcode)
          OP_LOAD, OP_ADD: nextState = S_OWAIT;
          OP_STORE: begin
            st.memWr  = 1'b1;
            nextState = S_ICHK;
          end
          OP_RETI: begin
            st.ctxRestore = 1'b1;
            nextState     = S_ICHK;
          end
          OP_HALT: nextState = S_HALT;
          default: nextState = S_ICHK;
        endcase
      end
      S_OWAIT: begin
        st.addrFromIr = 1'b1;
        st.accLoad    = (opcode == OP_LOAD);
        st.accAdd     = (opcode == OP_ADD);
        nextState     = S_ICHK;
      end
      S_ICHK: begin
        nextState = S_FETCH;
        if (irqReq && !masked) begin
          irqAck     = 1'b1;
          st.ctxSave = 1'b1;
        end
      end
      S_HALT: nextState = S_HALT;
      default: nextState = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_FETCH;
      masked <= 1'b0;
    end else begin
      state <= nextState;
      if (st.ctxSave)         masked <= 1'b1;
      else if (st.ctxRestore) masked <= 1'b0;
    end
  end

  AST_NO_ACK_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    masked |-> !irqAck); // R7
  AST_HALT_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HALT) |=> (state == S_HALT) && !st.memWr); // R9
endmodule

// File: rtl/accu_dpath.sv
module accu_dpath
  import accu_pkg::*;
#(
  parameter logic [ADDR_W-1:0] HANDLER = 12'h100
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              st,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic [OP_W-1:0]   opcode
);
  logic [ADDR_W-1:0] pc, pcSave;
  logic [DATA_W-1:0] ir, acc, accSave;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc      <= '0;
      ir      <= '0;
      acc     <= '0;
      pcSave  <= '0;
      accSave <= '0;
    end else begin
      if (st.irLoad) ir <= memRdata;
      if (st.ctxSave) begin
        pcSave  <= pc;
        accSave <= acc;
        pc      <= HANDLER;
      end else if (st.ctxRestore) begin
        pc <= pcSave;
      end else if (st.pcInc) begin
        pc <= pc + 1'b1;
      end
      if (st.ctxRestore)   acc <= accSave;
      else if (st.accLoad) acc <= memRdata;
      else if (st.accAdd)  acc <= acc + memRdata;
    end
  end

  assign memAddr  = st.addrFromIr ? ir[ADDR_W-1:0] : pc;
  assign memWdata = acc;
  assign memWe    = st.memWr;
  assign opcode   = ir[DATA_W-1 -: OP_W];

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    st.irLoad |=> pc == ADDR_W'($past(pc) + 1'b1)); // R2
  AST_ACC_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    st.ctxRestore |=> acc == $past(accSave)); // R8
endmodule

// File: rtl/accu_core.sv
module accu_core
  import accu_pkg::*;
#(
  parameter logic [ADDR_W-1:0] HANDLER = 12'h100
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memWe,
  input  logic              irqReq,
  output logic              irqAck
);
  ctrlT            st;
  logic [OP_W-1:0] opcode;

  accu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opcode(opcode), .irqReq(irqReq),
    .st(st), .irqAck(irqAck)
  );

  accu_dpath #(.HANDLER(HANDLER)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .opcode(opcode)
  );

  AST_ACK_VECTORS: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |=> memAddr == HANDLER); // R6
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe); // R3
endmodule

// File: tb/sim_accu_core.sv
module sim_accu_core;
  localparam int DW = 16;
  localparam int AW = 12;
  localparam int MW = 512;
  localparam int PLEN = 24;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata, memRdata;
  logic          memWe, irqReq, irqAck;

  logic [DW-1:0] mem    [MW];
  logic [DW-1:0] refMem [MW];
  logic [AW-1:0] wA [$];
  logic [DW-1:0] wD [$];
  logic [AW-1:0] eA [$];
  logic [DW-1:0] eD [$];
  int vecs = 0, bad = 0;

  accu_core u0 (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memWe(memWe), .irqReq(irqReq), .irqAck(irqAck)
  );

  always @(posedge clk) begin
    if (memWe) begin
      mem[memAddr[8:0]] <= memWdata;
      wA.push_back(memAddr);
      wD.push_back(memWdata);
    end
    memRdata <= mem[memAddr[8:0]];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ins(input logic [3:0] op, input logic [AW-1:0] a);
    return {op, a};
  endfunction

  // bench interpreter: expected write trace of a program without interrupts
  function automatic void runRef();
    logic [AW-1:0] pc = '0;
    logic [DW-1:0] acc = '0;
    eA.delete(); eD.delete();
    for (int n = 0; n < 1000; n++) begin
      logic [DW-1:0] w = refMem[pc[8:0]];
      logic [AW-1:0] a = w[AW-1:0];
      pc = pc + 1'b1;
      case (w[15:12])
        4'b0000: break;
        4'b0001: acc = refMem[a[8:0]];
        4'b0010: begin refMem[a[8:0]] = acc; eA.push_back(a); eD.push_back(acc); end
        4'b0101: acc = acc + refMem[a[8:0]];
        default: ;
      endcase
    end
  endfunction

  task automatic clearMem();
    for (int i = 0; i < MW; i++) mem[i] = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0; irqReq = 1'b0;
    repeat (3) @(negedge clk);
    chk(memAddr == 0 && !memWe && !irqAck, "R1 reset outputs", {memAddr, memWe, irqAck}, 0);
    wA.delete(); wD.delete();
    rstN = 1'b1;
    @(negedge clk);
    chk(memAddr == 0 && !memWe && !irqAck, "R1 first fetch address", {memAddr, memWe, irqAck}, 0);
  endtask

  task automatic waitHalt();
    logic [AW-1:0] last = '1;
    int same = 0;
    bit ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (memAddr == last && !memWe) same++; else same = 0;
      last = memAddr;
      if (same >= 10) begin ok = 1; break; end
    end
    chk(ok, "R9 halt reached", 32'(ok), 1);
  endtask

  task automatic checkHaltHolds();
    int cnt = wA.size();
    logic [AW-1:0] a = memAddr;
    bit quiet = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (memWe || memAddr != a) quiet = 0;
    end
    chk(quiet && wA.size() == cnt, "R9 halted stays idle", 32'(wA.size()), 32'(cnt));
  endtask

  task automatic compareTrace(input string tag);
    chk(wA.size() == eA.size(), {tag, " write count"}, 32'(wA.size()), 32'(eA.size()));
    for (int i = 0; i < eA.size() && i < wA.size(); i++)
      chk(wA[i] == eA[i] && wD[i] == eD[i], {tag, " store addr/data"}, {wA[i], wD[i]}, {eA[i], eD[i]});
  endtask

  initial begin
    rstN = 1'b0; irqReq = 1'b0;
    void'($urandom(32'h5eed1234));

    // Directed: acc cleared by reset, nop keeps acc (R1, R10, R3)
    clearMem();
    mem[0] = ins(4'b0010, 12'h060);
    mem[1] = ins(4'b0001, 12'h061);
    mem[2] = ins(4'b0111, 12'h062);
    mem[3] = ins(4'b1010, 12'h063);
    mem[4] = ins(4'b0010, 12'h064);
    mem[5] = ins(4'b0000, 12'h000);
    mem[9'h60] = 16'hFFFF; mem[9'h61] = 16'h1234;
    doReset();
    waitHalt();
    chk(wA.size() == 2, "R3 store count", 32'(wA.size()), 2);
    if (wA.size() == 2) begin
      chk(wD[0] == 16'h0000, "R1 acc cleared by reset", wD[0], 0);
      chk(wD[1] == 16'h1234 && wA[1] == 12'h064, "R10 nop keeps acc R4 load", {wA[1], wD[1]}, {12'h064, 16'h1234});
    end
    checkHaltHolds();

    // Directed: add wraps modulo 2^16 (R5)
    clearMem();
    mem[0] = ins(4'b0001, 12'h070);
    mem[1] = ins(4'b0101, 12'h071);
    mem[2] = ins(4'b0010, 12'h072);
    mem[3] = ins(4'b0000, 12'h000);
    mem[9'h70] = 16'hFFF0; mem[9'h71] = 16'h0025;
    doReset();
    waitHalt();
    chk(wA.size() == 1 && wD[0] == 16'h0015, "R5 add wraps", (wA.size() > 0) ? wD[0] : 16'hdead, 16'h0015);

    // Random programs (R2, R3, R4, R5, R10)
    for (int p = 0; p < 8; p++) begin
      clearMem();
      for (int i = 0; i < PLEN; i++) begin
        logic [3:0] op;
        case ($urandom % 7)
          0, 1: op = 4'b0001;
          2, 3: op = 4'b0010;
          4, 5: op = 4'b0101;
          default: op = ($urandom % 2) ? 4'b0011 : 4'b1001;
        endcase
        mem[i] = ins(op, 12'h040 + 12'($urandom % 8));
      end
      mem[PLEN] = ins(4'b0000, 12'h000);
      for (int i = 0; i < 8; i++) mem[9'h40 + i] = 16'($urandom);
      for (int i = 0; i < MW; i++) refMem[i] = mem[i];
      runRef();
      doReset();
      waitHalt();
      compareTrace("R2 R4 R5 random program");
    end

    // Directed interrupt: vectoring, masking, return (R6, R7, R8)
    clearMem();
    mem[0] = ins(4'b0001, 12'h040);
    mem[1] = ins(4'b0101, 12'h041);
    mem[2] = ins(4'b0010, 12'h042);
    mem[3] = ins(4'b0010, 12'h043);
    mem[4] = ins(4'b0000, 12'h000);
    mem[9'h40] = 16'h1111; mem[9'h41] = 16'h2222; mem[9'h50] = 16'hABCD;
    mem[9'h100] = ins(4'b0001, 12'h050);
    mem[9'h101] = ins(4'b0010, 12'h051);
    mem[9'h102] = ins(4'b1111, 12'h000);
    doReset();
    repeat (2) @(negedge clk);
    irqReq = 1'b1;
    begin
      bit seen = 0;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (irqAck) begin seen = 1; break; end
      end
      chk(seen, "R6 ack seen", 32'(seen), 1);
      @(negedge clk);
      chk(memAddr == 12'h100, "R6 handler fetch address", memAddr, 12'h100);
      begin
        int extra = 0;
        for (int i = 0; i < 8; i++) begin
          if (irqAck) extra++;
          @(negedge clk);
        end
        chk(extra == 0, "R7 no ack while masked", 32'(extra), 0);
      end
    end
    irqReq = 1'b0;
    waitHalt();
    chk(wA.size() == 3, "R8 write count after return", 32'(wA.size()), 3);
    if (wA.size() == 3) begin
      chk(wA[0] == 12'h051 && wD[0] == 16'hABCD, "R6 handler store", {wA[0], wD[0]}, {12'h051, 16'hABCD});
      chk(wA[1] == 12'h042 && wD[1] == 16'h3333, "R8 acc restored", {wA[1], wD[1]}, {12'h042, 16'h3333});
      chk(wA[2] == 12'h043 && wD[2] == 16'h3333, "R8 pc restored", {wA[2], wD[2]}, {12'h043, 16'h3333});
    end
    checkHaltHolds();

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    vecs++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule